// File: doc/BRIEF.md
# Dual-Strobe Byte-Lane DRAM Control Decoder

This block is the memory-side control logic of a x16 multiplexed-address DRAM that has a separate column strobe for each byte lane. A fast system clock samples the active-low row strobe, the two column strobes, the write enable, the output enable and the 10-bit multiplexed address. From these samples the block does the following:

- It merges the two column strobes into one internal column strobe.
- It classifies each cycle.
- It latches the row and column halves of the address.
- It decides when write data is captured.
- It drives per-lane output data with its own per-lane drive enable.

Storage is a synchronous array that is split into two independently written byte halves. The pad-level tristate buffers are left to the instantiating logic, which uses `dq_out` together with `dq_oe`.

All strobe and address inputs pass through one sampling register. A change at the pins therefore shows at the outputs within four clock edges.

Top module: `dualstrobe_ctrl`

## Requirements
- R1: The internal column strobe is asserted while either `casl_n` or `cash_n` is low. The column address is latched only when the internal strobe first asserts. A second strobe that falls later in the same period uses that latched column, even if `addr` has changed.
- R2: `casl_n` owns data bits 7:0 and `dq_oe[0]`. `cash_n` owns bits 15:8 and `dq_oe[1]`. A lane drives only while its own strobe is low, so one strobe gives a byte access and both give a word access.
- R3: The row is latched when `ras_n` falls and the column when the internal strobe falls. The storage word is addressed by the row's low `ROW_BITS` bits followed by the column's low `COL_BITS` bits of `addr`. The upper address bits are ignored.
- R4: `cyc_class` reports the most recent cycle type:
  - 0 means none since reset.
  - 1 means access. It is set when the internal strobe falls while `ras_n` is low.
  - 2 means strobe-before-row refresh. It is set when `ras_n` falls while a column strobe is already low.
  - 3 means row-only refresh. It is set when `ras_n` rises after a low period with no column strobe fall.
- R5: With `we_n` high at a lane's strobe fall, the lane drives the stored byte whenever its strobe and `oe_n` are both low. The drive ends once the strobe rises.
- R6: With `we_n` already low when a lane's strobe falls (early write), that lane does not drive for the rest of its strobe period. The byte on `din` is stored.
- R7: If `we_n` falls after the lane's strobe in an access (read-write), `din` is stored at the `we_n` fall. The lane keeps driving the previously read byte while its strobe and `oe_n` stay low.
- R8: Raising `oe_n` during a read removes the drive. Lowering it again while the strobe is still low drives the same read byte again.
- R9: If a column strobe is low when `ras_n` falls (hidden refresh), a lane that is already driving keeps its output data and drive until its strobe rises.
- R10: A lane whose strobe never falls in a cycle neither drives nor changes its stored byte.
- R11: `mode_err` is set when, within one internal strobe period of an access, the second lane's strobe falls with a different `we_n` level than the first lane's. It clears when the next internal strobe period begins.
- R12: After reset, `dq_oe` is 0, `cyc_class` is 0 and `mode_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-lane column strobe, active low |
| cash_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 2*LANE_W | Write data from the pads |
| dq_out | output | 2*LANE_W | Read data toward the pads |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 lower, bit 1 upper) |
| cyc_class | output | 2 | Last cycle class (0 none, 1 access, 2 strobe-before-row refresh, 3 row-only refresh) |
| mode_err | output | 1 | Lanes disagreed on write mode in one strobe period |

## Verification
A row or column latched at the wrong edge shows up as wrong read data at the next access to that word, within the same strobe period. A wrong per-lane arming state shows as `dq_oe` set during an early write, or as a lane driving after its strobe rises, within four clock edges of the strobe change. A wrong refresh or access decision appears on `cyc_class` a few edges after the `ras_n` edge that settles it. A bad write latch point corrupts a lane, and later word reads made by the random mix against the reference array expose that corruption.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_ACCESS = 2'd1,
    CLS_CBR    = 2'd2,
    CLS_RONLY  = 2'd3
  } cyc_cls_e;
endpackage

// File: rtl/dsc_sampler.sv
// Single register stage on all pins plus one stage of history for edge detection.
// Sampled strobes are converted to active-high.
module dsc_sampler #(
  parameter int IW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_n,
  input  logic [1:0]    cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          ras_s,
  output logic          ras_p,
  output logic [1:0]    cas_s,
  output logic [1:0]    cas_p,
  output logic          we_s,
  output logic          oe_s,
  output logic [IW-1:0] addr_s,
  output logic [DW-1:0] din_s
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_s  <= 1'b0;
      ras_p  <= 1'b0;
      cas_s  <= '0;
      cas_p  <= '0;
      we_s   <= 1'b0;
      oe_s   <= 1'b0;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      ras_s  <= ~ras_n;
      ras_p  <= ras_s;
      cas_s  <= ~cas_n;
      cas_p  <= cas_s;
      we_s   <= ~we_n;
      oe_s   <= ~oe_n;
      addr_s <= addr;
      din_s  <= din;
    end
  end
endmodule

// File: rtl/dsc_classifier.sv
// Internal strobe merge, address latches, cycle classification and lane mode check.
module dsc_classifier
  import dsc_pkg::*;
#(
  parameter int RB = 4,
  parameter int CB = 4,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ras_s,
  input  logic          ras_p,
  input  logic [1:0]    cas_s,
  input  logic [1:0]    cas_p,
  input  logic          we_s,
  input  logic [IW-1:0] addr_s,
  output logic [RB-1:0] row_now,
  output logic [CB-1:0] col_now,
  output logic          acc_ok,
  output cyc_cls_e      cls,
  output logic          mode_err
);
  logic icas, icas_p, icas_fell, ras_fell, ras_rose, cbr_start, second_fell;
  logic cbr_q, seen_q, mvld_q, mode_q;
  logic [RB-1:0] row_q;
  logic [CB-1:0] col_q;

  assign icas        = |cas_s;
  assign icas_p      = |cas_p;
  assign icas_fell   = icas & ~icas_p;
  assign ras_fell    = ras_s & ~ras_p;
  assign ras_rose    = ~ras_s & ras_p;
  assign cbr_start   = ras_fell & icas_p;
  assign acc_ok      = ras_s & ~cbr_q & ~cbr_start;
  assign second_fell = (|(cas_s & ~cas_p)) & (&cas_s) & icas_p;
  assign row_now     = ras_fell  ? addr_s[RB-1:0] : row_q;
  assign col_now     = icas_fell ? addr_s[CB-1:0] : col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      col_q    <= '0;
      cbr_q    <= 1'b0;
      seen_q   <= 1'b0;
      mvld_q   <= 1'b0;
      mode_q   <= 1'b0;
      mode_err <= 1'b0;
      cls      <= CLS_NONE;
    end else begin
      if (ras_fell)  row_q <= addr_s[RB-1:0];
      if (icas_fell) col_q <= addr_s[CB-1:0];
      if (cbr_start) begin
        cbr_q <= 1'b1;
        cls   <= CLS_CBR;
      end else if (ras_rose) begin
        cbr_q  <= 1'b0;
        seen_q <= 1'b0;
        if (!seen_q && !cbr_q) cls <= CLS_RONLY;
      end
      if (icas_fell && acc_ok) begin
        seen_q <= 1'b1;
        cls    <= CLS_ACCESS;
      end
      if (icas_fell) begin
        mvld_q   <= acc_ok;
        mode_q   <= we_s;
        mode_err <= 1'b0;
      end else if (second_fell && acc_ok && mvld_q && (we_s != mode_q)) begin
        mode_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsc_lane.sv
// One byte lane: storage half, read-data hold register and drive decision.
module dsc_lane #(
  parameter int W  = 8,
  parameter int XB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strb_s,
  input  logic          strb_p,
  input  logic          we_s,
  input  logic          oe_s,
  input  logic          acc_ok,
  input  logic [XB-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  dq,
  output logic          drive
);
  localparam int DEPTH = 1 << XB;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;
  logic fell, rd_en, wcond, wprev_q, wr_en, armed_q, pend_q, rdy_q;

  assign fell  = strb_s & ~strb_p;
  assign rd_en = fell & acc_ok;
  assign wcond = strb_s & we_s & acc_ok;
  assign wr_en = wcond & ~wprev_q;

  // Block-RAM style array: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
    if (rd_en) rd_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wprev_q <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
      dq      <= '0;
      drive   <= 1'b0;
    end else begin
      wprev_q <= wcond;
      pend_q  <= rd_en;
      if (rd_en)       armed_q <= ~we_s;
      else if (!strb_s) armed_q <= 1'b0;
      if (rd_en)       rdy_q <= 1'b0;
      else if (pend_q) begin
        rdy_q <= 1'b1;
        dq    <= rd_q;
      end
      drive <= armed_q & rdy_q & strb_s & oe_s;
    end
  end
endmodule

// File: rtl/dualstrobe_ctrl.sv
module dualstrobe_ctrl
  import dsc_pkg::*;
#(
  parameter int AW       = 10,
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int LANE_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ras_n,
  input  logic                    casl_n,
  input  logic                    cash_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_oe,
  output logic [1:0]              cyc_class,
  output logic                    mode_err
);
  localparam int IW = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int XB = ROW_BITS + COL_BITS;
  localparam int DW = LANES * LANE_W;

  logic          ras_s, ras_p, we_s, oe_s, acc_ok;
  logic [1:0]    cas_s, cas_p;
  logic [IW-1:0] addr_s;
  logic [DW-1:0] din_s;
  logic [ROW_BITS-1:0] row_now;
  logic [COL_BITS-1:0] col_now;
  cyc_cls_e cls_w;

  generate
    if (IW < AW) begin : g_hi_addr
      logic unused_hi_addr;
      assign unused_hi_addr = ^addr[AW-1:IW];
    end
  endgenerate

  dsc_sampler #(.IW(IW), .DW(DW)) u_smp (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n({cash_n, casl_n}),
    .we_n(we_n), .oe_n(oe_n), .addr(addr[IW-1:0]), .din(din),
    .ras_s(ras_s), .ras_p(ras_p), .cas_s(cas_s), .cas_p(cas_p),
    .we_s(we_s), .oe_s(oe_s), .addr_s(addr_s), .din_s(din_s)
  );

  dsc_classifier #(.RB(ROW_BITS), .CB(COL_BITS), .IW(IW)) u_cls (
    .clk(clk), .rst(rst), .ras_s(ras_s), .ras_p(ras_p), .cas_s(cas_s),
    .cas_p(cas_p), .we_s(we_s), .addr_s(addr_s), .row_now(row_now),
    .col_now(col_now), .acc_ok(acc_ok), .cls(cls_w), .mode_err(mode_err)
  );

  assign cyc_class = cls_w;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      dsc_lane #(.W(LANE_W), .XB(XB)) u_lane (
        .clk(clk), .rst(rst), .strb_s(cas_s[g]), .strb_p(cas_p[g]),
        .we_s(we_s), .oe_s(oe_s), .acc_ok(acc_ok), .idx({row_now, col_now}),
        .wdata(din_s[g*LANE_W +: LANE_W]), .dq(dq_out[g*LANE_W +: LANE_W]),
        .drive(dq_oe[g])
      );
    end
  endgenerate

  // R2
  lo_lane_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe[0] |-> !$past(casl_n, 2));
  // R2
  hi_lane_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe[1] |-> !$past(cash_n, 2));
  // R8
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (|dq_oe) |-> !$past(oe_n, 2));
  // R4
  access_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_class == CLS_ACCESS && $past(cyc_class) != CLS_ACCESS) |-> !$past(ras_n, 2));
  // R4
  ronly_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_class == CLS_RONLY && $past(cyc_class) != CLS_RONLY) |-> $past(ras_n, 2));
  // R11
  mode_err_both_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_err) |-> (!$past(casl_n, 2) && !$past(cash_n, 2)));
endmodule

// File: tb/tb_dualstrobe_ctrl.sv
`timescale 1ns/1ps
module tb_dualstrobe_ctrl;
  localparam int AW = 10, RB = 4, CB = 4, NW = 1 << (RB + CB);

  logic clk = 1'b0, rst = 1'b1;
  logic ras_n = 1, casl_n = 1, cash_n = 1, we_n = 1, oe_n = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq_out;
  logic [1:0] dq_oe, cyc_class;
  logic mode_err;
  logic [15:0] ref_mem [NW];
  int tests = 0, fails = 0;

  dualstrobe_ctrl dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out),
    .dq_oe(dq_oe), .cyc_class(cyc_class), .mode_err(mode_err)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ix(input logic [AW-1:0] ra, input logic [AW-1:0] ca);
    return int'({ra[RB-1:0], ca[CB-1:0]});
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] ln);
    return {ln[1] ? d[15:8] : old[15:8], ln[0] ? d[7:0] : old[7:0]};
  endfunction

  task automatic check_lanes(input logic [1:0] ln, input logic [15:0] e, input string req);
    chk(dq_oe == ln, req, dq_oe, ln);
    if (ln[0]) chk(dq_out[7:0] == e[7:0], req, dq_out[7:0], e[7:0]);
    if (ln[1]) chk(dq_out[15:8] == e[15:8], req, dq_out[15:8], e[15:8]);
  endtask

  // R5 R3 R2 read with the given lanes
  task automatic rd(input logic [AW-1:0] ra, input logic [AW-1:0] ca, input logic [1:0] ln);
    logic [15:0] e;
    e = ref_mem[ix(ra, ca)];
    addr = ra; ras_n = 0; tick(2);
    addr = ca; casl_n = ~ln[0]; cash_n = ~ln[1]; tick(6);
    check_lanes(ln, e, "R5 read data/drive");
    chk(cyc_class == 2'd1, "R4 access class", cyc_class, 1);
    chk(mode_err == 1'b0, "R11 no error for matching lanes", mode_err, 0);
    casl_n = 1; cash_n = 1; tick(4);
    chk(dq_oe == 2'b00, "R5 no drive after strobe rise", dq_oe, 0);
    ras_n = 1; tick(3);
  endtask

  // R6 early write
  task automatic ew(input logic [AW-1:0] ra, input logic [AW-1:0] ca, input logic [1:0] ln, input logic [15:0] d);
    addr = ra; ras_n = 0; tick(2);
    we_n = 0; din = d; addr = ca; tick(1);
    casl_n = ~ln[0]; cash_n = ~ln[1]; tick(6);
    chk(dq_oe == 2'b00, "R6 early write no drive", dq_oe, 0);
    casl_n = 1; cash_n = 1; tick(2);
    we_n = 1; tick(1); ras_n = 1; tick(3);
    ref_mem[ix(ra, ca)] = merge(ref_mem[ix(ra, ca)], d, ln);
  endtask

  // R7 read-write with late write enable
  task automatic lw(input logic [AW-1:0] ra, input logic [AW-1:0] ca, input logic [1:0] ln, input logic [15:0] d);
    logic [15:0] e;
    e = ref_mem[ix(ra, ca)];
    addr = ra; ras_n = 0; tick(2);
    addr = ca; casl_n = ~ln[0]; cash_n = ~ln[1]; tick(6);
    check_lanes(ln, e, "R7 read before late write");
    we_n = 0; din = d; tick(5);
    check_lanes(ln, e, "R7 old data held after late write");
    chk(mode_err == 1'b0, "R11 late write not a mode mix", mode_err, 0);
    casl_n = 1; cash_n = 1; tick(2);
    we_n = 1; tick(1); ras_n = 1; tick(3);
    ref_mem[ix(ra, ca)] = merge(e, d, ln);
  endtask

  initial begin
    logic [15:0] e, d;
    void'($urandom(32'h51c3));
    tick(5);
    chk(dq_oe == 2'b00, "R12 reset drive", dq_oe, 0);
    chk(cyc_class == 2'd0, "R12 reset class", cyc_class, 0);
    chk(mode_err == 1'b0, "R12 reset error", mode_err, 0);
    rst = 0; tick(3);
    chk(dq_oe == 2'b00 && cyc_class == 2'd0, "R12 idle after reset", {dq_oe, cyc_class}, 0);

    // Fill every word with a word-wide early write.
    for (int a = 0; a < NW; a++) begin
      ref_mem[a] = 16'h0;
      ew(AW'(a >> CB), AW'(a % (1 << CB)), 2'b11, {8'(a), 8'(~a)});
    end

    rd(10'h003, 10'h005, 2'b11);
    rd(10'h0f3, 10'h3c5, 2'b01); // R3 upper pin bits ignored
    rd(10'h003, 10'h005, 2'b10);

    // R10 byte write to the lower lane leaves the upper lane untouched and idle
    e = ref_mem[ix(10'h7, 10'h9)];
    addr = 10'h7; ras_n = 0; tick(2);
    we_n = 0; din = 16'hA55A; addr = 10'h9; tick(1);
    casl_n = 0; tick(6);
    chk(dq_oe[1] == 1'b0, "R10 idle lane never drives", dq_oe, 0);
    casl_n = 1; tick(2); we_n = 1; tick(1); ras_n = 1; tick(3);
    ref_mem[ix(10'h7, 10'h9)] = {e[15:8], 8'h5A};
    rd(10'h7, 10'h9, 2'b11); // R10 upper byte kept

    lw(10'h2, 10'h4, 2'b11, 16'h1357);
    rd(10'h2, 10'h4, 2'b11);
    lw(10'h2, 10'h4, 2'b10, 16'hBEEF);
    rd(10'h2, 10'h4, 2'b11);

    // R1 stagger: second strobe uses column latched at the first fall
    e = ref_mem[ix(10'h5, 10'h1)];
    addr = 10'h5; ras_n = 0; tick(2);
    addr = 10'h1; casl_n = 0; tick(2);
    addr = 10'h2; tick(2);
    cash_n = 0; tick(6);
    check_lanes(2'b11, e, "R1 column from first strobe");
    casl_n = 1; tick(4);
    check_lanes(2'b10, e, "R2 upper still driven after lower rises");
    cash_n = 1; tick(4);
    chk(dq_oe == 2'b00, "R1 internal strobe ends at last rise", dq_oe, 0);
    ras_n = 1; tick(3);

    // R8 output enable toggling
    e = ref_mem[ix(10'h9, 10'hA)];
    addr = 10'h9; ras_n = 0; tick(2);
    addr = 10'hA; casl_n = 0; cash_n = 0; tick(6);
    oe_n = 1; tick(4);
    chk(dq_oe == 2'b00, "R8 oe high removes drive", dq_oe, 0);
    oe_n = 0; tick(4);
    check_lanes(2'b11, e, "R8 drive returns with same data");
    // R9 hidden refresh keeps data while strobes stay low
    ras_n = 1; tick(3);
    addr = 10'h3; ras_n = 0; tick(5);
    chk(cyc_class == 2'd2, "R9 hidden refresh classed as strobe-first", cyc_class, 2);
    check_lanes(2'b11, e, "R9 output held through hidden refresh");
    casl_n = 1; cash_n = 1; tick(4);
    chk(dq_oe == 2'b00, "R9 drive ends at strobe rise", dq_oe, 0);
    ras_n = 1; tick(3);

    // R4 strobe-before-row refresh
    casl_n = 0; cash_n = 0; tick(3);
    ras_n = 0; tick(5);
    chk(cyc_class == 2'd2, "R4 strobe-before-row refresh", cyc_class, 2);
    chk(dq_oe == 2'b00, "R4 refresh does not drive", dq_oe, 0);
    casl_n = 1; cash_n = 1; tick(2); ras_n = 1; tick(4);
    chk(cyc_class == 2'd2, "R4 class kept after refresh end", cyc_class, 2);

    // R4 row-only refresh
    addr = 10'h6; ras_n = 0; tick(4); ras_n = 1; tick(5);
    chk(cyc_class == 2'd3, "R4 row-only refresh", cyc_class, 3);
    rd(10'h6, 10'h6, 2'b01);

    // R11 lanes in different modes in one strobe period
    d = 16'h00C3;
    addr = 10'hB; ras_n = 0; tick(2);
    addr = 10'hC; we_n = 0; din = d; tick(1);
    casl_n = 0; tick(3);
    we_n = 1; tick(1);
    cash_n = 0; tick(5);
    chk(mode_err == 1'b1, "R11 mode mix flagged", mode_err, 1);
    chk(dq_oe[0] == 1'b0, "R6 early lane stays idle", dq_oe, 0);
    casl_n = 1; cash_n = 1; tick(2); ras_n = 1; tick(3);
    ref_mem[ix(10'hB, 10'hC)] = merge(ref_mem[ix(10'hB, 10'hC)], d, 2'b01);
    rd(10'hB, 10'hC, 2'b11); // R11 cleared by next period

    // Random mix against the reference array.
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] ra, ca;
      logic [1:0] ln;
      int op;
      ra = {6'($urandom_range(0, 63)), 4'($urandom_range(0, 15))};
      ca = {6'($urandom_range(0, 63)), 4'($urandom_range(0, 15))};
      ln = 2'($urandom_range(1, 3));
      op = $urandom_range(0, 2);
      d  = 16'($urandom());
      case (op)
        0: rd(ra, ca, ln);
        1: ew(ra, ca, ln, d);
        default: lw(ra, ca, ln, d);
      endcase
    end
    for (int a = 0; a < 16; a++) rd(AW'(a), AW'(15 - a), 2'b11);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule